// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block drives a byte-level I2C master engine through complete transfers. A request carries a 7-bit target address, an operation (write, read, or write followed by read), a transmit byte count and a receive byte count. While busy, the sequencer reacts to each 8-bit status code the engine reports. For each code it issues one command: start, stop, write a byte, or read a byte with ACK or NACK.

Transmit bytes come from a caller-owned buffer, addressed by an index the sequencer drives. Received bytes leave through a write port that carries an index and the data. A combined transfer switches from writing to reading with a repeated start. Only the final read byte is answered with NACK. When the engine reports lost arbitration, the whole transfer restarts from the beginning. At the end the sequencer raises done with a result code of OK, NACK or bus error, and holds both until the next request is accepted.

Top module: `i2c_txn_seq`

## Requirements
- R1: A request is taken only while `busy` is low. Taking it raises `busy`, clears `done` and pulses `cmd_start` one cycle later. A request while busy has no effect.
- R2: After status 0x08 or 0x10, `cmd_write` carries `{address, rw}`. `rw` is 1 for a read (op 1), and for a combined transfer (op 2 or 3) once no transmit bytes are left. Otherwise `rw` is 0.
- R3: After status 0x18 or 0x28, while transmit bytes remain, `cmd_write` carries the buffer byte at `tx_idx`. The index runs from 0 upward.
- R4: After status 0x18 or 0x28 with no transmit bytes left, a repeated `cmd_start` is issued if receive bytes remain. Otherwise `cmd_stop` is issued and `done` rises with result 0 (OK). Every completion issues `cmd_stop`.
- R5: After status 0x40, and after status 0x50, `cmd_read` is issued. `cmd_ack` is 1 only if more than one byte then remains. On status 0x50 the byte on `rx_data` is first written out through `rx_we`/`rx_waddr`/`rx_wdata` at the next index, starting at 0.
- R6: Status 0x58 writes the last byte out, issues `cmd_stop` and completes with result 0 (OK).
- R7: Status 0x20, 0x30 or 0x48 issues `cmd_stop` and completes with result 1 (NACK).
- R8: Status 0x38 issues `cmd_start` without completing. The transfer then replays from its first byte.
- R9: Status 0x00, 0xF8 or any unlisted code issues `cmd_stop` with `cmd_byte` = 0xFF and completes with result 2 (bus error).
- R10: Status is ignored while `evt_valid` is low, and also while idle.
- R11: `done` and `result` hold their values until the next request is accepted. `done` is never high together with `busy`.
- R12: Each command is a single-cycle pulse one cycle after its cause. At most one of start, stop, write and read is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 write, 1 read, 2/3 write then read |
| req_addr | input | 7 | Target address |
| req_ntx | input | CW | Bytes to write (ignored for op 1) |
| req_nrx | input | CW | Bytes to read (ignored for op 0) |
| busy | output | 1 | Transfer in progress |
| tx_idx | output | CW | Transmit buffer index |
| tx_data | input | 8 | Buffer byte at `tx_idx` |
| evt_valid | input | 1 | Engine status strobe |
| evt_status | input | 8 | Engine status code |
| rx_data | input | 8 | Byte received by the engine |
| cmd_start | output | 1 | Start / repeated start command |
| cmd_stop | output | 1 | Stop command |
| cmd_write | output | 1 | Write `cmd_byte` command |
| cmd_read | output | 1 | Read-byte command |
| cmd_ack | output | 1 | ACK (1) or NACK (0) for the read |
| cmd_byte | output | 8 | Byte for the engine |
| rx_we | output | 1 | Received byte write strobe |
| rx_waddr | output | CW | Received byte index |
| rx_wdata | output | 8 | Received byte |
| done | output | 1 | Transfer finished |
| result | output | 2 | 0 OK, 1 NACK, 2 bus error |

## Verification
The assertions assume that `req_valid` and `evt_valid` are low during reset. They also assume the engine reports at most one status per cycle and only in reply to a command. The bench plays the engine. It answers each observed command with exactly one status one cycle later, so every cause-to-command relation the assertions check is well formed. Random transfers use read counts of at least one whenever a read phase exists. This matches a real engine, which never sends a read-address ACK for a zero-length read.

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq #(
  parameter int MAX_BYTES = 15,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [6:0]    req_addr,
  input  logic [CW-1:0] req_ntx,
  input  logic [CW-1:0] req_nrx,
  output logic          busy,
  output logic [CW-1:0] tx_idx,
  input  logic [7:0]    tx_data,
  input  logic          evt_valid,
  input  logic [7:0]    evt_status,
  input  logic [7:0]    rx_data,
  output logic          cmd_start,
  output logic          cmd_stop,
  output logic          cmd_write,
  output logic          cmd_read,
  output logic          cmd_ack,
  output logic [7:0]    cmd_byte,
  output logic          rx_we,
  output logic [CW-1:0] rx_waddr,
  output logic [7:0]    rx_wdata,
  output logic          done,
  output logic [1:0]    result
);
  localparam logic [7:0] ST_START = 8'h08, ST_RSTART = 8'h10, ST_ARB = 8'h38;
  localparam logic [7:0] ST_WA_ACK = 8'h18, ST_WA_NAK = 8'h20;
  localparam logic [7:0] ST_WD_ACK = 8'h28, ST_WD_NAK = 8'h30;
  localparam logic [7:0] ST_RA_ACK = 8'h40, ST_RA_NAK = 8'h48;
  localparam logic [7:0] ST_RD_ACK = 8'h50, ST_RD_NAK = 8'h58;
  localparam logic [1:0] RES_OK = 2'd0, RES_NAK = 2'd1, RES_ERR = 2'd2;

  logic [1:0]    op_q;
  logic [6:0]    addr_q;
  logic [CW-1:0] ntx_q, nrx_q, tx_left, rx_left, rx_cnt;

  wire          rd_bit = (op_q == 2'd1) || (op_q[1] && tx_left == '0);
  wire          rx_any = rx_left != '0;
  wire [CW-1:0] rx_dec = rx_any ? rx_left - 1'b1 : rx_left;
  wire [CW-1:0] ntx_in = (req_op == 2'd1) ? '0 : req_ntx;
  wire [CW-1:0] nrx_in = (req_op == 2'd0) ? '0 : req_nrx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; result <= RES_OK;
      op_q <= '0; addr_q <= '0; ntx_q <= '0; nrx_q <= '0;
      tx_left <= '0; rx_left <= '0; tx_idx <= '0; rx_cnt <= '0;
      cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_write <= 1'b0; cmd_read <= 1'b0;
      cmd_ack <= 1'b0; cmd_byte <= 8'hFF;
      rx_we <= 1'b0; rx_waddr <= '0; rx_wdata <= '0;
    end else begin
      cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_write <= 1'b0; cmd_read <= 1'b0;
      rx_we <= 1'b0;
      if (!busy && req_valid) begin
        op_q <= req_op; addr_q <= req_addr;
        ntx_q <= ntx_in; nrx_q <= nrx_in;
        tx_left <= ntx_in; rx_left <= nrx_in;
        tx_idx <= '0; rx_cnt <= '0;
        busy <= 1'b1; done <= 1'b0; result <= RES_OK;
        cmd_start <= 1'b1;
      end else if (busy && evt_valid) begin
        case (evt_status)
          ST_START, ST_RSTART: begin
            cmd_write <= 1'b1;
            cmd_byte  <= {addr_q, rd_bit};
          end
          ST_WA_ACK, ST_WD_ACK: begin
            if (tx_left != '0) begin
              cmd_write <= 1'b1;
              cmd_byte  <= tx_data;
              tx_idx    <= tx_idx + 1'b1;
              tx_left   <= tx_left - 1'b1;
            end else if (rx_any) begin
              cmd_start <= 1'b1;
            end else begin
              cmd_stop <= 1'b1; busy <= 1'b0; done <= 1'b1; result <= RES_OK;
            end
          end
          ST_RA_ACK: begin
            cmd_read <= 1'b1;
            cmd_ack  <= rx_left > 1;
          end
          ST_RD_ACK: begin
            if (rx_any) begin
              rx_we <= 1'b1; rx_waddr <= rx_cnt; rx_wdata <= rx_data;
              rx_cnt <= rx_cnt + 1'b1;
            end
            rx_left  <= rx_dec;
            cmd_read <= 1'b1;
            cmd_ack  <= rx_dec > 1;
          end
          ST_RD_NAK: begin
            if (rx_any) begin
              rx_we <= 1'b1; rx_waddr <= rx_cnt; rx_wdata <= rx_data;
              rx_cnt <= rx_cnt + 1'b1;
            end
            rx_left  <= rx_dec;
            cmd_stop <= 1'b1; busy <= 1'b0; done <= 1'b1; result <= RES_OK;
          end
          ST_WA_NAK, ST_WD_NAK, ST_RA_NAK: begin
            cmd_stop <= 1'b1; busy <= 1'b0; done <= 1'b1; result <= RES_NAK;
          end
          ST_ARB: begin
            tx_left <= ntx_q; rx_left <= nrx_q;
            tx_idx <= '0; rx_cnt <= '0;
            cmd_start <= 1'b1;
          end
          default: begin
            cmd_byte <= 8'hFF;
            cmd_stop <= 1'b1; busy <= 1'b0; done <= 1'b1; result <= RES_ERR;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       evt_valid,
  input logic [7:0] evt_status,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       cmd_start,
  input logic       cmd_stop,
  input logic       cmd_write,
  input logic       cmd_read,
  input logic [7:0] cmd_byte,
  input logic       rx_we
);
  wire any_cmd = cmd_start | cmd_stop | cmd_write | cmd_read;

  assert_one_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_start, cmd_stop, cmd_write, cmd_read}));

  assert_cmd_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cmd || rx_we) |-> $past(evt_valid || req_valid));

  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_start && $past(req_valid)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && !$past(req_valid)) |-> !any_cmd);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(result));

  assert_finish_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cmd_stop);

  assert_err_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && result == 2'd2) |-> cmd_byte == 8'hFF);

  assert_store_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> $past(evt_valid && evt_status[7:4] == 4'h5));
endmodule

bind i2c_txn_seq i2c_txn_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .evt_valid(evt_valid),
  .evt_status(evt_status), .busy(busy), .done(done), .result(result),
  .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_write(cmd_write),
  .cmd_read(cmd_read), .cmd_byte(cmd_byte), .rx_we(rx_we)
);

// File: tb/i2c_txn_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_txn_seq_tb_top;
  localparam int MAXB = 15;
  localparam int CW = $clog2(MAXB + 1);
  localparam logic [3:0] K_NONE = 4'b0000, K_START = 4'b1000, K_STOP = 4'b0100,
                         K_WR = 4'b0010, K_RD = 4'b0001;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, evt_valid;
  logic [1:0] req_op;
  logic [6:0] req_addr;
  logic [CW-1:0] req_ntx, req_nrx, tx_idx, rx_waddr;
  logic [7:0] tx_data, evt_status, rx_data, cmd_byte, rx_wdata;
  logic busy, cmd_start, cmd_stop, cmd_write, cmd_read, cmd_ack, rx_we, done;
  logic [1:0] result;
  logic [7:0] tx_mem [16];

  assign tx_data = tx_mem[tx_idx];

  i2c_txn_seq #(.MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ntx(req_ntx), .req_nrx(req_nrx), .busy(busy),
    .tx_idx(tx_idx), .tx_data(tx_data), .evt_valid(evt_valid),
    .evt_status(evt_status), .rx_data(rx_data), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_write(cmd_write), .cmd_read(cmd_read),
    .cmd_ack(cmd_ack), .cmd_byte(cmd_byte), .rx_we(rx_we), .rx_waddr(rx_waddr),
    .rx_wdata(rx_wdata), .done(done), .result(result)
  );

  int total = 0, bad = 0, cycles = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] cmdv();
    return {cmd_start, cmd_stop, cmd_write, cmd_read};
  endfunction

  task automatic expect_cmd(logic [3:0] k, logic [7:0] b, bit ack, string tag);
    chk(cmdv() == k, {tag, " cmd"}, cmdv(), k);
    if (k == K_WR) chk(cmd_byte == b, {tag, " byte"}, cmd_byte, b);
    if (k == K_RD) chk(cmd_ack == ack, {tag, " ack"}, cmd_ack, ack);
  endtask

  task automatic expect_end(logic [1:0] res, string tag);
    expect_cmd(K_STOP, 8'h00, 1'b0, tag);
    chk(done && !busy, {tag, " done"}, {done, busy}, 2'b10);
    chk(result == res, {tag, " result"}, result, res);
  endtask

  task automatic evt(logic [7:0] st, logic [7:0] b);
    evt_valid = 1'b1; evt_status = st; rx_data = b;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic request(logic [1:0] op, logic [6:0] a, int nt, int nr);
    req_valid = 1'b1; req_op = op; req_addr = a;
    req_ntx = CW'(nt); req_nrx = CW'(nr);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic bit rd_bit(logic [1:0] op, int tl);
    return (op == 2'd1) || (op[1] && tl == 0);
  endfunction

  // Engine model: runs from just after a cmd_start has been observed.
  task automatic flow(logic [1:0] op, logic [6:0] a, int txn, int rxn);
    int tl = txn;
    bit rep = 1'b0;
    while (1) begin
      bit rd = rd_bit(op, tl);
      evt(rep ? 8'h10 : 8'h08, 8'h00);
      expect_cmd(K_WR, {a, rd}, 1'b0, "R2 address");
      if (!rd) begin
        evt(8'h18, 8'h00);
        for (int i = 0; i < tl; i++) begin
          expect_cmd(K_WR, tx_mem[i], 1'b0, "R3 tx byte");
          evt(8'h28, 8'h00);
        end
        tl = 0;
        if (rxn > 0) begin
          expect_cmd(K_START, 8'h00, 1'b0, "R4 repeated start");
          rep = 1'b1;
        end else begin
          expect_end(2'd0, "R4 write end");
          return;
        end
      end else begin
        evt(8'h40, 8'h00);
        expect_cmd(K_RD, 8'h00, rxn > 1, "R5 first read");
        for (int i = 0; i < rxn; i++) begin
          logic [7:0] b = 8'($urandom);
          bit last = (i == rxn - 1);
          evt(last ? 8'h58 : 8'h50, b);
          chk(rx_we && rx_waddr == CW'(i) && rx_wdata == b, "R5 rx store",
              {rx_we, 4'(rx_waddr), rx_wdata}, {1'b1, 4'(i), b});
          if (last) expect_end(2'd0, "R6 read end");
          else expect_cmd(K_RD, 8'h00, (rxn - 1 - i) > 1, "R5 next read");
        end
        return;
      end
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 16; i++) tx_mem[i] = 8'($urandom);
  endtask

  task automatic txn(logic [1:0] op, logic [6:0] a, int nt, int nr);
    request(op, a, nt, nr);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    chk(busy && !done, "R1 busy", {busy, done}, 2'b10);
    flow(op, a, (op == 2'd1) ? 0 : nt, (op == 2'd0) ? 0 : nr);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd4242);
    if (seed == 0) fill_mem();
    rst_n = 1'b0; req_valid = 1'b0; evt_valid = 1'b0; req_op = '0;
    req_addr = '0; req_ntx = '0; req_nrx = '0; evt_status = 8'h00; rx_data = '0;
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && cmdv() == K_NONE && !rx_we, "R11 reset state",
        {busy, done, cmdv()}, 0);

    txn(2'd0, 7'h3A, 3, 0);
    txn(2'd1, 7'h51, 7, 3);
    txn(2'd1, 7'h05, 0, 1);
    txn(2'd2, 7'h60, 2, 2);
    txn(2'd2, 7'h61, 0, 2);
    txn(2'd0, 7'h12, 0, 0);

    evt(8'h18, 8'h00);
    expect_cmd(K_NONE, 8'h00, 1'b0, "R10 idle event");
    chk(done && result == 2'd0, "R11 held after idle event", {done, result}, 3'b100);

    request(2'd0, 7'h11, 1, 0);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    chk(!done, "R11 done cleared", done, 0);
    request(2'd1, 7'h22, 0, 4);
    expect_cmd(K_NONE, 8'h00, 1'b0, "R1 busy request");
    evt_status = 8'h08;
    @(negedge clk);
    expect_cmd(K_NONE, 8'h00, 1'b0, "R10 no strobe");
    flow(2'd0, 7'h11, 1, 0);

    request(2'd0, 7'h2B, 2, 0);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    evt(8'h08, 8'h00);
    expect_cmd(K_WR, {7'h2B, 1'b0}, 1'b0, "R2 address");
    evt(8'h20, 8'h00);
    expect_end(2'd1, "R7 address nack");
    repeat (3) @(negedge clk);
    chk(done && result == 2'd1, "R11 result held", {done, result}, 3'b101);

    request(2'd0, 7'h2C, 2, 0);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    evt(8'h08, 8'h00);
    evt(8'h18, 8'h00);
    expect_cmd(K_WR, tx_mem[0], 1'b0, "R3 tx byte");
    evt(8'h30, 8'h00);
    expect_end(2'd1, "R7 data nack");

    request(2'd1, 7'h2D, 0, 2);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    evt(8'h08, 8'h00);
    expect_cmd(K_WR, {7'h2D, 1'b1}, 1'b0, "R2 read address");
    evt(8'h48, 8'h00);
    expect_end(2'd1, "R7 read address nack");

    request(2'd2, 7'h44, 2, 2);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    evt(8'h08, 8'h00);
    evt(8'h18, 8'h00);
    expect_cmd(K_WR, tx_mem[0], 1'b0, "R3 tx byte");
    evt(8'h28, 8'h00);
    expect_cmd(K_WR, tx_mem[1], 1'b0, "R3 tx byte");
    evt(8'h38, 8'h00);
    expect_cmd(K_START, 8'h00, 1'b0, "R8 restart");
    chk(busy && !done, "R8 no completion", {busy, done}, 2'b10);
    flow(2'd2, 7'h44, 2, 2);

    request(2'd0, 7'h70, 3, 0);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    evt(8'h08, 8'h00);
    evt(8'h00, 8'h00);
    expect_end(2'd2, "R9 bus error");
    chk(cmd_byte == 8'hFF, "R9 release byte", cmd_byte, 8'hFF);

    request(2'd1, 7'h71, 0, 2);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    evt(8'hF8, 8'h00);
    expect_end(2'd2, "R9 no-info code");
    chk(cmd_byte == 8'hFF, "R9 release byte", cmd_byte, 8'hFF);

    request(2'd0, 7'h72, 1, 0);
    expect_cmd(K_START, 8'h00, 1'b0, "R1 start");
    evt(8'h08, 8'h00);
    evt(8'h77, 8'h00);
    expect_end(2'd2, "R9 unknown code");

    for (int n = 0; n < 40; n++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      fill_mem();
      txn(op, 7'($urandom), $urandom_range(0, 6), $urandom_range(1, 6));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule